// File: doc/BRIEF.md
# Access Error Capture Logic

This block sits beside the request path of an external memory controller. Every system request that reaches the controller is classified on the same clock. A request for the configuration registers is legal only inside a 1 KB window. A request for external memory must land in exactly one enabled chip-select region. A region is defined by a base value and a size mask. When a request fails either test, the block raises an unsupported-address error.

Only the first illegal access is kept. Its cause code and its address are held until software writes the clear strobe. While a captured error waits for that clear, later faults are dropped. If a clear and a new fault arrive on the same edge, the new fault wins. No error is ever lost to that race.

Top module: `access_error_capture`

## Requirements
- R1: After reset, `err_valid` is 0, `err_type` is 4'h0 and `err_addr` is 0.
- R2: A memory request (`req_is_reg`=0) is legal when exactly one region i has `cs_enable[i]`=1 and (`req_addr` & `cs_mask[i]`) == `cs_base[i]`. A memory request matching no enabled region is an error with cause 2'b01.
- R3: A region whose enable bit is 0 never matches, whatever its base and mask.
- R4: A memory request matching two or more enabled regions is an error with cause 2'b10 (overlap).
- R5: A register request (`req_is_reg`=1) is legal when `req_addr` < 1024. Otherwise it is an error with cause 2'b11. Chip-select decoding plays no part in register requests.
- R6: A captured error appears on the edge that samples the request. From the next cycle, `err_valid`=1 and `err_type` = {cause[1:0], 1'b1, 1'b1}: bit 0 is the valid flag, bit 1 is the unsupported-address flag, and bits 3:2 hold the cause. `err_addr` holds the request address.
- R7: While `err_valid` is 1 and `err_clear` is 0, further faulty requests leave `err_type` and `err_addr` unchanged.
- R8: `err_clear` with no new fault in the same cycle returns `err_valid`, `err_type` and `err_addr` to 0 in the next cycle.
- R9: A fault in the same cycle as `err_clear` is captured, replacing the old record.
- R10: A cycle with `req_valid`=0, or with a legal request, never sets `err_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_is_reg | input | 1 | Request targets the register space |
| cs_enable | input | NUM_CS | Per-region enable |
| cs_base | input | NUM_CS x ADDR_W | Per-region base value |
| cs_mask | input | NUM_CS x ADDR_W | Per-region size mask |
| err_clear | input | 1 | Clear strobe from a status write |
| err_valid | output | 1 | An error record is held |
| err_type | output | 4 | {cause, unsupported flag, valid flag} |
| err_addr | output | ADDR_W | Address of the captured request |

## Verification
The hardest situation to reach is a clear strobe and a new fault landing on the same edge. The bench reaches it by first capturing a register-range fault. It then drives the clear together with an unmapped memory request in one cycle, and checks that the second cause and address replace the first. Overlap is reached only by enabling a second region whose mask covers part of another region. The bench therefore first shows that the same address passes, or fails as unmapped, while that region is disabled.

// File: rtl/acc_err_pkg.sv
package acc_err_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_NOHIT    = 2'b01,
    CAUSE_OVERLAP  = 2'b10,
    CAUSE_REGRANGE = 2'b11
  } cause_e;

  localparam int ERR_TYPE_W = 4;

  // Packs a cause into the error-type layout: {cause, unsupported, valid}
  function automatic logic [ERR_TYPE_W-1:0] pack_type(input cause_e c);
    return {c, 1'b1, 1'b1};
  endfunction

endpackage

// File: rtl/cs_region_match.sv
module cs_region_match #(
  parameter int ADDR_W = 32
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  function automatic logic region_hit(input logic en,
                                      input logic [ADDR_W-1:0] b,
                                      input logic [ADDR_W-1:0] m,
                                      input logic [ADDR_W-1:0] a);
    return en && ((a & m) == b);
  endfunction

  assign hit = region_hit(enable, base, mask, addr);

endmodule

// File: rtl/req_classifier.sv
module req_classifier
  import acc_err_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int ADDR_W    = 32,
  parameter int REG_WIN_W = 10,
  localparam int CNT_W    = $clog2(NUM_CS + 1)
) (
  input  logic              req_valid,
  input  logic              req_is_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NUM_CS-1:0] hit_vec,
  output logic [CNT_W-1:0]  hit_count,
  output logic              no_hit,
  output logic              multi_hit,
  output logic              reg_oor,
  output logic              err_event,
  output cause_e            err_cause
);

  function automatic logic [CNT_W-1:0] count_hits(input logic [NUM_CS-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_CS; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic outside_window(input logic [ADDR_W-1:0] a);
    return |a[ADDR_W-1:REG_WIN_W];
  endfunction

  assign hit_count = count_hits(hit_vec);
  assign no_hit    = req_valid && !req_is_reg && (hit_count == '0);
  assign multi_hit = req_valid && !req_is_reg && (hit_count > CNT_W'(1));
  assign reg_oor   = req_valid && req_is_reg && outside_window(req_addr);
  assign err_event = no_hit || multi_hit || reg_oor;

  always_comb begin
    if (reg_oor)        err_cause = CAUSE_REGRANGE;
    else if (multi_hit) err_cause = CAUSE_OVERLAP;
    else if (no_hit)    err_cause = CAUSE_NOHIT;
    else                err_cause = CAUSE_NONE;
  end

endmodule

// File: rtl/err_latch.sv
module err_latch
  import acc_err_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  err_event,
  input  cause_e                err_cause,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  err_clear,
  output logic                  capture_en,
  output logic                  err_valid,
  output logic [ERR_TYPE_W-1:0] err_type,
  output logic [ADDR_W-1:0]     err_addr
);

  logic                  valid_q;
  logic [ERR_TYPE_W-1:0] type_q;
  logic [ADDR_W-1:0]     addr_q;

  assign capture_en = err_event && (!valid_q || err_clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      type_q  <= '0;
      addr_q  <= '0;
    end else if (capture_en) begin
      valid_q <= 1'b1;
      type_q  <= pack_type(err_cause);
      addr_q  <= req_addr;
    end else if (err_clear) begin
      valid_q <= 1'b0;
      type_q  <= '0;
      addr_q  <= '0;
    end
  end

  assign err_valid = valid_q;
  assign err_type  = type_q;
  assign err_addr  = addr_q;

endmodule

// File: rtl/access_error_capture.sv
module access_error_capture
  import acc_err_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int ADDR_W    = 32,
  parameter int REG_WIN_W = 10,
  localparam int CNT_W    = $clog2(NUM_CS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic                           req_is_reg,
  input  logic [NUM_CS-1:0]              cs_enable,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  cs_base,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  cs_mask,
  input  logic                           err_clear,
  output logic                           err_valid,
  output logic [ERR_TYPE_W-1:0]          err_type,
  output logic [ADDR_W-1:0]              err_addr
);

  // Named internal events, visible to the bound checker
  logic [NUM_CS-1:0] hit_vec;
  logic [CNT_W-1:0]  hit_count;
  logic              no_hit;
  logic              multi_hit;
  logic              reg_oor;
  logic              err_event;
  cause_e            err_cause;
  logic              capture_en;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_region
    cs_region_match #(.ADDR_W(ADDR_W)) u_match (
      .enable (cs_enable[g]),
      .base   (cs_base[g]),
      .mask   (cs_mask[g]),
      .addr   (req_addr),
      .hit    (hit_vec[g])
    );
  end

  req_classifier #(
    .NUM_CS    (NUM_CS),
    .ADDR_W    (ADDR_W),
    .REG_WIN_W (REG_WIN_W)
  ) u_class (
    .req_valid  (req_valid),
    .req_is_reg (req_is_reg),
    .req_addr   (req_addr),
    .hit_vec    (hit_vec),
    .hit_count  (hit_count),
    .no_hit     (no_hit),
    .multi_hit  (multi_hit),
    .reg_oor    (reg_oor),
    .err_event  (err_event),
    .err_cause  (err_cause)
  );

  err_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_event  (err_event),
    .err_cause  (err_cause),
    .req_addr   (req_addr),
    .err_clear  (err_clear),
    .capture_en (capture_en),
    .err_valid  (err_valid),
    .err_type   (err_type),
    .err_addr   (err_addr)
  );

endmodule

// File: rtl/acc_err_checker.sv
module acc_err_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_is_reg,
  input logic [ADDR_W-1:0] req_addr,
  input logic              err_clear,
  input logic [CNT_W-1:0]  hit_count,
  input logic              multi_hit,
  input logic              err_event,
  input logic              capture_en,
  input logic              err_valid,
  input logic [3:0]        err_type,
  input logic [ADDR_W-1:0] err_addr
);

  // R6: a capture shows up one cycle later with the request address
  p_capture_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (err_valid && err_type[1:0] == 2'b11 && err_addr == $past(req_addr)));

  // R7: a held record does not move without a clear
  p_hold_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_clear) |=> ($stable(err_addr) && $stable(err_type) && err_valid));

  // R8: clear without a new fault empties the record
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !err_event) |=> (!err_valid && err_type == 4'h0 && err_addr == '0));

  // R4: an overlap that is captured carries the overlap cause
  p_overlap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_hit && (!err_valid || err_clear)) |=> (err_type[3:2] == 2'b10));

  // R2: a single-region memory hit is not a fault
  p_single_hit_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_reg && hit_count == CNT_W'(1)) |-> !err_event);

  // R10: with no request there is no fault
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !err_event);

  // R9: fault together with clear still captures
  p_clear_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_event && err_clear) |=> err_valid);

endmodule

bind access_error_capture acc_err_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_is_reg (req_is_reg),
  .req_addr   (req_addr),
  .err_clear  (err_clear),
  .hit_count  (hit_count),
  .multi_hit  (multi_hit),
  .err_event  (err_event),
  .capture_en (capture_en),
  .err_valid  (err_valid),
  .err_type   (err_type),
  .err_addr   (err_addr)
);

// File: tb/sim_access_error_capture.sv
`timescale 1ns/1ps
module sim_access_error_capture;

  localparam int NCS = 4;
  localparam int AW  = 32;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   req_valid = 1'b0;
  logic [AW-1:0]          req_addr = '0;
  logic                   req_is_reg = 1'b0;
  logic [NCS-1:0]         cs_enable = '0;
  logic [NCS-1:0][AW-1:0] cs_base = '0;
  logic [NCS-1:0][AW-1:0] cs_mask = '0;
  logic                   err_clear = 1'b0;
  logic                   err_valid;
  logic [3:0]             err_type;
  logic [AW-1:0]          err_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  access_error_capture #(.NUM_CS(NCS), .ADDR_W(AW), .REG_WIN_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_reg(req_is_reg), .cs_enable(cs_enable), .cs_base(cs_base),
    .cs_mask(cs_mask), .err_clear(err_clear), .err_valid(err_valid),
    .err_type(err_type), .err_addr(err_addr)
  );

  // Expected type word: {cause, unsupported=1, valid=1}
  function automatic logic [3:0] exp_type(input logic [1:0] cause);
    return {cause, 2'b11};
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request cycle; outputs are sampled on the following falling edge
  task automatic issue(input logic v, input logic isreg, input logic [AW-1:0] a, input logic clr);
    @(negedge clk);
    req_valid = v; req_is_reg = isreg; req_addr = a; err_clear = clr;
    @(negedge clk);
    req_valid = 1'b0; req_is_reg = 1'b0; req_addr = '0; err_clear = 1'b0;
  endtask

  task automatic check_record(input string req, input logic v, input logic [3:0] t, input logic [AW-1:0] a);
    chk(req, AW'(err_valid), AW'(v));
    chk(req, AW'(err_type), AW'(t));
    chk(req, err_addr, a);
  endtask

  task automatic t_reset;
    check_record("R1 reset", 1'b0, 4'h0, '0);
  endtask

  task automatic t_legal;
    issue(1'b1, 1'b0, 32'h0123_4560, 1'b0);
    check_record("R2 single hit legal", 1'b0, 4'h0, '0);
    issue(1'b0, 1'b0, 32'h3000_0000, 1'b0);
    check_record("R10 idle unmapped", 1'b0, 4'h0, '0);
  endtask

  task automatic t_unmapped_and_hold;
    issue(1'b1, 1'b0, 32'h3000_0040, 1'b0);
    check_record("R2 R6 unmapped capture", 1'b1, exp_type(2'b01), 32'h3000_0040);
    issue(1'b1, 1'b1, 32'h0000_0800, 1'b0);
    check_record("R7 second error ignored", 1'b1, exp_type(2'b01), 32'h3000_0040);
    issue(1'b0, 1'b0, '0, 1'b1);
    check_record("R8 clear", 1'b0, 4'h0, '0);
  endtask

  task automatic t_disabled_region;
    issue(1'b1, 1'b0, 32'h2F00_0000, 1'b0);
    check_record("R3 disabled region no match", 1'b1, exp_type(2'b01), 32'h2F00_0000);
    issue(1'b0, 1'b0, '0, 1'b1);
    @(negedge clk); cs_enable[3] = 1'b1;
    issue(1'b1, 1'b0, 32'h2F00_0000, 1'b0);
    check_record("R3 enabled region matches", 1'b0, 4'h0, '0);
  endtask

  task automatic t_overlap;
    issue(1'b1, 1'b0, 32'h2000_1000, 1'b0);
    check_record("R4 overlap", 1'b1, exp_type(2'b10), 32'h2000_1000);
    issue(1'b0, 1'b0, '0, 1'b1);
    check_record("R8 clear after overlap", 1'b0, 4'h0, '0);
  endtask

  task automatic t_register;
    issue(1'b1, 1'b1, 32'h0000_03FC, 1'b0);
    check_record("R5 reg in window", 1'b0, 4'h0, '0);
    issue(1'b1, 1'b1, 32'h3000_0000, 1'b0);
    check_record("R5 reg ignores cs decode", 1'b1, exp_type(2'b11), 32'h3000_0000);
    issue(1'b0, 1'b0, '0, 1'b1);
    issue(1'b1, 1'b1, 32'h0000_0400, 1'b0);
    check_record("R5 reg out of window", 1'b1, exp_type(2'b11), 32'h0000_0400);
  endtask

  task automatic t_clear_race;
    issue(1'b1, 1'b0, 32'h3000_0100, 1'b1);
    check_record("R9 clear with new error", 1'b1, exp_type(2'b01), 32'h3000_0100);
    issue(1'b0, 1'b0, '0, 1'b1);
    check_record("R8 final clear", 1'b0, 4'h0, '0);
  endtask

  initial begin
    // Region map: CS0 0x0xxx_xxxx, CS1 0x1xxx_xxxx, CS2 0x20xx_xxxx,
    // CS3 0x2xxx_xxxx (starts disabled; overlaps CS2 when enabled)
    cs_base[0] = 32'h0000_0000; cs_mask[0] = 32'hF000_0000;
    cs_base[1] = 32'h1000_0000; cs_mask[1] = 32'hF000_0000;
    cs_base[2] = 32'h2000_0000; cs_mask[2] = 32'hFF00_0000;
    cs_base[3] = 32'h2000_0000; cs_mask[3] = 32'hF000_0000;
    cs_enable  = 4'b0111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legal();
    t_unmapped_and_hold();
    t_disabled_region();
    t_overlap();
    t_register();
    t_clear_race();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule